// File: doc/BRIEF.md
# Fetch-Time Return Address Predictor

This block predicts where a subroutine return will go while the return is still being fetched. A small table, indexed and tagged by the fetch PC, holds one kind per learned instruction: none, call or return. It holds no target. The lookup is combinational on the fetch PC. When a valid fetch hits a call entry, the address just after the call (fetch PC + 4) is pushed onto a circular return stack at the next clock edge. When it hits a return entry, the top of the stack is presented as the predicted target in the same cycle and is popped at the edge. No decode stage is in this path, so the fetch stream keeps going without a bubble.

Decode trains the table through a write port. It writes or overwrites the entry for a PC whenever the table missed a call or return, or classified one wrongly. When the return resolves, the predicted target and the resolved target are presented to a check port. A mismatch raises a one-cycle redirect that carries the correct target.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty, `pred_hit` is 0 and `redirect` is 0.
- R2: A valid fetch whose PC has no valid table entry with a matching tag neither pushes nor pops, and gives `pred_hit` = 0.
- R3: A cycle with `train_valid` high writes `train_kind` into the table entry for `train_pc`. The codes are 0 none, 1 call and 2 return. The entry index is PC bits [5:2] with the default 16 entries. Later fetches of that PC behave according to the stored kind.
- R4: A valid fetch classified as a call pushes fetch PC + 4. A later valid fetch classified as a return, with the stack not empty, shows that address on `pred_target` with `pred_hit` = 1 in its own fetch cycle, and pops it.
- R5: Nested calls are returned in last-in first-out order.
- R6: With the default depth of 8, a push onto a full stack overwrites the oldest entry. After 9 calls, 8 returns give the 8 newest return addresses, newest first, and a 9th return gives `pred_hit` = 0.
- R7: A return fetched with the stack empty gives `pred_hit` = 0, shows the entry at the top position, and leaves the pointer unchanged. Right after reset that entry is 0. A following call and return still predict correctly.
- R8: A PC that shares a table index with a trained return but has a different tag is a miss. It does not pop.
- R9: Retraining a PC with kind 0 stops it from acting. Retraining it with kind 2 makes it act as a return again.
- R10: When `chk_valid` is high and `chk_pred` differs from `chk_actual`, `redirect` is 1 one cycle later and `redirect_target` equals `chk_actual`. When the two match, or `chk_valid` is low, `redirect` is 0 one cycle later.
- R11: With `fetch_valid` low there is no push and no pop, and `pred_hit` is 0, whatever the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | PC_W | Fetch address |
| train_valid | input | 1 | Write a classification entry |
| train_pc | input | PC_W | PC being classified |
| train_kind | input | 2 | 0 none, 1 call, 2 return |
| chk_valid | input | 1 | Resolved return is presented |
| chk_pred | input | PC_W | Target that was predicted |
| chk_actual | input | PC_W | Target that was resolved |
| pred_target | output | PC_W | Predicted return target (top of stack) |
| pred_hit | output | 1 | Fetch is a learned return and the stack holds an entry |
| redirect | output | 1 | Registered mismatch flag |
| redirect_target | output | PC_W | Correct target that goes with `redirect` |

## Verification
The hardest state to reach is wrap-around. Nine trained calls must be fetched in a row so that the ring laps and overwrites its oldest slot. The drain that follows must then cross the wrap point and stop exactly at the empty condition. The stimulus first trains nine call PCs that fill nine distinct table indices. It fetches all of them, then fetches the trained return nine times, and the scoreboard expects eight newest-first targets and then a miss. Tag aliasing and retraining are reached by fetching a PC that shares the return's index and by rewriting the return's entry between fetches. In both cases an item is left on the stack as a witness that nothing was popped.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_CALL = 2'd1,
        KIND_RET  = 2'd2
    } kind_e;
endpackage

// File: rtl/ras_kind_table.sv
module ras_kind_table #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output ras_pkg::kind_e    lk_kind,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [1:0]        wr_kind
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][1:0]       kind;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;

    // index skips the two byte-offset bits; they are folded into the tag
    assign lk_idx = lk_pc[IDX_W+1:2];
    assign wr_idx = wr_pc[IDX_W+1:2];
    assign lk_tag = {lk_pc[PC_W-1:IDX_W+2], lk_pc[1:0]};
    assign wr_tag = {wr_pc[PC_W-1:IDX_W+2], wr_pc[1:0]};

    assign lk_kind = (tbl_q.vld[lk_idx] && (tbl_q.tag[lk_idx] == lk_tag))
                     ? ras_pkg::kind_e'(tbl_q.kind[lk_idx]) : ras_pkg::KIND_NONE;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.vld[wr_idx]  = 1'b1;
            tbl_d.tag[wr_idx]  = wr_tag;
            tbl_d.kind[wr_idx] = wr_kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end
endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [PC_W-1:0]              push_addr,
    output logic [PC_W-1:0]              top_addr,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] mem;
        logic [PTR_W-1:0]           ptr;
        logic [CNT_W-1:0]           cnt;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] ptr_up, ptr_dn;

    assign ptr_up   = (st_q.ptr == PTR_MAX) ? '0 : st_q.ptr + 1'b1;
    assign ptr_dn   = (st_q.ptr == '0) ? PTR_MAX : st_q.ptr - 1'b1;
    assign top_addr = st_q.mem[st_q.ptr];
    assign empty    = (st_q.cnt == '0);
    assign count    = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push) begin
            // ring: a push onto a full stack lands on the oldest slot
            st_d.ptr         = ptr_up;
            st_d.mem[ptr_up] = push_addr;
            if (st_q.cnt != CNT_FULL) st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && !empty) begin
            st_d.ptr = ptr_dn;
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ras_check.sv
module ras_check #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chk_valid,
    input  logic [PC_W-1:0] chk_pred,
    input  logic [PC_W-1:0] chk_actual,
    output logic            redirect,
    output logic [PC_W-1:0] redirect_target
);
    typedef struct packed {
        logic            redir;
        logic [PC_W-1:0] tgt;
    } chk_t;

    chk_t ck_d, ck_q;

    always_comb begin
        ck_d       = ck_q;
        ck_d.redir = chk_valid && (chk_pred != chk_actual);
        if (chk_valid) ck_d.tgt = chk_actual;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_q <= '0;
        else        ck_q <= ck_d;
    end

    assign redirect        = ck_q.redir;
    assign redirect_target = ck_q.tgt;
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
    parameter int PC_W        = 32,
    parameter int DEPTH       = 8,
    parameter int TBL_ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            train_valid,
    input  logic [PC_W-1:0] train_pc,
    input  logic [1:0]      train_kind,
    input  logic            chk_valid,
    input  logic [PC_W-1:0] chk_pred,
    input  logic [PC_W-1:0] chk_actual,
    output logic [PC_W-1:0] pred_target,
    output logic            pred_hit,
    output logic            redirect,
    output logic [PC_W-1:0] redirect_target
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    ras_pkg::kind_e   fetch_kind;
    logic             is_call, is_ret, stk_empty;
    logic [CNT_W-1:0] stk_count;
    logic [PC_W-1:0]  stk_top;

    ras_kind_table #(.PC_W(PC_W), .ENTRIES(TBL_ENTRIES)) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(fetch_pc), .lk_kind(fetch_kind),
        .wr_en(train_valid), .wr_pc(train_pc), .wr_kind(train_kind)
    );

    assign is_call = fetch_valid && (fetch_kind == ras_pkg::KIND_CALL);
    assign is_ret  = fetch_valid && (fetch_kind == ras_pkg::KIND_RET);

    ras_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(is_call), .pop(is_ret),
        .push_addr(fetch_pc + PC_W'(4)),
        .top_addr(stk_top), .empty(stk_empty), .count(stk_count)
    );

    assign pred_target = stk_top;
    assign pred_hit    = is_ret && !stk_empty;

    ras_check #(.PC_W(PC_W)) u_check (
        .clk(clk), .rst_n(rst_n),
        .chk_valid(chk_valid), .chk_pred(chk_pred), .chk_actual(chk_actual),
        .redirect(redirect), .redirect_target(redirect_target)
    );
endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fetch_valid,
    input logic                       pred_hit,
    input logic                       chk_valid,
    input logic [PC_W-1:0]            chk_pred,
    input logic [PC_W-1:0]            chk_actual,
    input logic                       redirect,
    input logic [PC_W-1:0]            redirect_target,
    input logic [$clog2(DEPTH+1)-1:0] stk_count
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    a_r11_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !pred_hit);

    a_r7_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_count == '0) |-> !pred_hit);

    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        stk_count <= CNT_W'(DEPTH));

    a_r4_hit_pops: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |=> (stk_count == $past(stk_count) - 1'b1));

    a_r10_mismatch_redirects: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && (chk_pred != chk_actual)) |=>
            (redirect && (redirect_target == $past(chk_actual))));

    a_r10_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_valid && (chk_pred != chk_actual)) |=> !redirect);
endmodule

bind ras_predictor ras_checker #(.PC_W(PC_W), .DEPTH(DEPTH)) u_ras_checker (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .pred_hit(pred_hit),
    .chk_valid(chk_valid), .chk_pred(chk_pred), .chk_actual(chk_actual),
    .redirect(redirect), .redirect_target(redirect_target), .stk_count(stk_count)
);

// File: tb/test_ras_predictor.sv
module test_ras_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 32;
    localparam logic [31:0] RET_PC   = 32'h13C;
    localparam logic [31:0] ALIAS_PC = 32'h23C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fetch_valid = 1'b0, train_valid = 1'b0, chk_valid = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0, train_pc = '0, chk_pred = '0, chk_actual = '0;
    logic [1:0] train_kind = 2'd0;
    logic [PC_W-1:0] pred_target, redirect_target;
    logic pred_hit, redirect;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic       q_hit[$];
    logic       q_care[$];
    logic [31:0] q_tgt[$];
    string      q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ras_predictor i_ras_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .train_valid(train_valid), .train_pc(train_pc), .train_kind(train_kind),
        .chk_valid(chk_valid), .chk_pred(chk_pred), .chk_actual(chk_actual),
        .pred_target(pred_target), .pred_hit(pred_hit),
        .redirect(redirect), .redirect_target(redirect_target)
    );

    function automatic logic [31:0] cpc(int i);
        return 32'h100 + 32'(4 * i);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each valid fetch against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && fetch_valid && q_hit.size() > 0) begin
            logic e_hit, e_care; logic [31:0] e_tgt; string e_tag;
            e_hit = q_hit.pop_front(); e_care = q_care.pop_front();
            e_tgt = q_tgt.pop_front(); e_tag = q_tag.pop_front();
            check(pred_hit == e_hit, {e_tag, " hit"}, 32'(pred_hit), 32'(e_hit));
            if (e_care)
                check(pred_target == e_tgt, {e_tag, " target"}, pred_target, e_tgt);
        end
    end

    task automatic fetch(logic [31:0] pc, logic e_hit, logic e_care,
                         logic [31:0] e_tgt, string tag);
        @(posedge clk); #1;
        fetch_valid = 1'b1; fetch_pc = pc;
        q_hit.push_back(e_hit); q_care.push_back(e_care);
        q_tgt.push_back(e_tgt); q_tag.push_back(tag);
        @(posedge clk); #1;
        fetch_valid = 1'b0;
    endtask

    task automatic train(logic [31:0] pc, logic [1:0] kind);
        @(posedge clk); #1;
        train_valid = 1'b1; train_pc = pc; train_kind = kind;
        @(posedge clk); #1;
        train_valid = 1'b0;
    endtask

    task automatic chk(logic [31:0] p, logic [31:0] a, logic e_redir, string tag);
        @(posedge clk); #1;
        chk_valid = 1'b1; chk_pred = p; chk_actual = a;
        @(posedge clk); #1;
        chk_valid = 1'b0;
        @(negedge clk);
        check(redirect == e_redir, {tag, " redirect"}, 32'(redirect), 32'(e_redir));
        if (e_redir)
            check(redirect_target == a, {tag, " redirect_target"}, redirect_target, a);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pred_hit == 1'b0, "R1 reset pred_hit", 32'(pred_hit), 0);
        check(redirect == 1'b0, "R1 reset redirect", 32'(redirect), 0);
        rst_n = 1'b1;

        // R2: untrained PCs do nothing
        fetch(RET_PC, 1'b0, 1'b0, '0, "R2 untrained return");
        fetch(cpc(0), 1'b0, 1'b0, '0, "R2 untrained call");
        train(RET_PC, 2'd2);
        // stack still empty: the untrained call pushed nothing (R2, R7 top is 0)
        fetch(RET_PC, 1'b0, 1'b1, 32'h0, "R7 underflow after reset");

        // R3: train calls
        for (int i = 0; i < 9; i++) train(cpc(i), 2'd1);

        // R7 pointer unchanged after underflow, then R4 basic call/return
        fetch(RET_PC, 1'b0, 1'b0, '0, "R7 underflow again");
        fetch(cpc(0), 1'b0, 1'b0, '0, "R3 call fetch");
        fetch(RET_PC, 1'b1, 1'b1, cpc(0) + 4, "R4 return predicts pc+4");

        // R5 nesting
        for (int i = 1; i <= 3; i++) fetch(cpc(i), 1'b0, 1'b0, '0, "R5 call");
        for (int i = 3; i >= 1; i--) fetch(RET_PC, 1'b1, 1'b1, cpc(i) + 4, "R5 lifo");
        fetch(RET_PC, 1'b0, 1'b0, '0, "R5 drained");

        // R11 idle fetch of a return PC
        fetch(cpc(4), 1'b0, 1'b0, '0, "R11 call");
        @(posedge clk); #1;
        fetch_valid = 1'b0; fetch_pc = RET_PC;
        @(negedge clk);
        check(pred_hit == 1'b0, "R11 idle pred_hit", 32'(pred_hit), 0);
        fetch(RET_PC, 1'b1, 1'b1, cpc(4) + 4, "R11 no pop while idle");

        // R6 overflow
        for (int i = 0; i < 9; i++) fetch(cpc(i), 1'b0, 1'b0, '0, "R6 call");
        for (int i = 8; i >= 1; i--) fetch(RET_PC, 1'b1, 1'b1, cpc(i) + 4, "R6 newest first");
        fetch(RET_PC, 1'b0, 1'b0, '0, "R6 oldest lost");

        // R8 alias
        fetch(cpc(5), 1'b0, 1'b0, '0, "R8 call");
        fetch(ALIAS_PC, 1'b0, 1'b0, '0, "R8 alias miss");
        fetch(RET_PC, 1'b1, 1'b1, cpc(5) + 4, "R8 alias did not pop");

        // R9 retrain
        fetch(cpc(6), 1'b0, 1'b0, '0, "R9 call");
        train(RET_PC, 2'd0);
        fetch(RET_PC, 1'b0, 1'b0, '0, "R9 cleared entry");
        train(RET_PC, 2'd2);
        fetch(RET_PC, 1'b1, 1'b1, cpc(6) + 4, "R9 retrained return");

        // R10 check port
        chk(32'h500, 32'h500, 1'b0, "R10 match");
        chk(32'h500, 32'h7A4, 1'b1, "R10 mismatch");
        @(negedge clk);
        check(redirect == 1'b0, "R10 one-cycle pulse", 32'(redirect), 0);

        repeat (3) @(posedge clk);
        check(q_hit.size() == 0, "R4 scoreboard drained", 32'(q_hit.size()), 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule